// File: doc/BRIEF.md
# Keyed Watchdog with Two-Stage Expiry

This block guards a processor against a stalled or runaway program. Software services it by writing one 32-bit control word that carries a 7-bit key, a start/run command bit and an 8-bit reload count. Once the watchdog has been started, a write is accepted only if its key is the exact bitwise inverse of the key held from the last accepted write. Software therefore has to alternate between a key and its inverse on each service, and a stray store of a fixed value cannot keep the watchdog alive.

The counter steps down once for each cycle on which the tick-enable input is high. In the intended system that input is driven from a slow tick near 760 Hz, which sits outside this block. When the count runs out for the first time, the block raises a non-maskable interrupt and reloads a short grace count, which gives the handler one last chance to service it. If the grace count also runs out, the block issues a one-cycle system reset request and stops counting.

Top module: `keyed_watchdog`

## Requirements
- R1: After a synchronous reset, the stored control word is 0, the count is 0, the counter is stopped, and nmi and reset_req are both low.
- R2: While bit 8 of the stored control word is 0, any write is accepted whatever key it carries. This includes the first write after reset.
- R3: While bit 8 of the stored control word is 1, a write is accepted only if wr_data[15:9] equals the bitwise inverse of the stored bits [15:9]. A rejected write changes nothing: not the control word, the count, nmi, the expiry stage or the run state.
- R4: An accepted write stores the whole 32-bit word as the control word. It also loads the counter from wr_data[7:0], and a field value of 0 loads 256. The control word and the count appear on ctrl_value and count_value one cycle after the write.
- R5: When bit 8 of an accepted write is 1, the counter runs. When it is 0, the counter stops and holds its loaded value.
- R6: A running counter decrements by one only on cycles where tick_en is 1. On all other cycles it holds.
- R7: A tick that arrives while a running count is 1 is an expiry. On the first expiry since the last accepted write, nmi goes high on the next cycle, count_value becomes GRACE (default 1) and the counter keeps running.
- R8: An expiry while nmi is already high drives reset_req high for exactly one cycle. The counter stops with count_value at 0, and nmi stays high.
- R9: An accepted write clears nmi and returns the block to the first expiry stage.
- R10: When an accepted write and a tick arrive in the same cycle, the write wins and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 32 | Control word: key [15:9], command [8], count [7:0] |
| tick_en | input | 1 | One-cycle tick that steps the counter |
| nmi | output | 1 | Non-maskable interrupt, registered |
| reset_req | output | 1 | One-cycle system reset request, registered |
| ctrl_value | output | 32 | Stored control word |
| count_value | output | 9 | Present count |

## Verification
The bench targets four boundary cases:
- A key that matches the stored key instead of its inverse. A design that got this wrong would let a constant refresh loop keep the watchdog alive.
- A count field of 0. If this is not handled, the counter wraps and expires at once instead of after 256 ticks.
- A write that lands in the same cycle as the expiring tick. If priority is wrong, a spurious NMI or reset slips through even though the watchdog was serviced.
- The grace expiry. If this is wrong, the reset request either repeats or never comes.

The bench also checks that no tick is counted while the counter is stopped or while tick_en is low. A long pseudo-random run then mixes valid keys, wrong keys and ticks, and the result is compared against the behavioural model on every cycle.

// File: rtl/keyed_watchdog_pkg.sv
package keyed_watchdog_pkg;
  typedef enum logic {
    STG_ARMED = 1'b0,
    STG_GRACE = 1'b1
  } stage_e;
endpackage

// File: rtl/wd_key_gate.sv
module wd_key_gate #(
  parameter int DATA_W  = 32,
  parameter int KEY_W   = 7,
  parameter int KEY_LSB = 9,
  parameter int CMD_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              accept,
  output logic [DATA_W-1:0] ctrl_q
);
  logic             armed;
  logic [KEY_W-1:0] want_key;

  assign armed    = ctrl_q[CMD_BIT];
  assign want_key = ~ctrl_q[KEY_LSB +: KEY_W];
  assign accept   = wr_en && (!armed || (wr_data[KEY_LSB +: KEY_W] == want_key));

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (accept) ctrl_q <= wr_data;
  end

  // R3: a write that fails the key check leaves the stored word untouched
  assert_reject_keeps_ctrl_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !accept) |=> $stable(ctrl_q));
  // R2: while the watchdog is not armed, every write lands
  assert_unarmed_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ctrl_q[CMD_BIT]) |=> (ctrl_q == $past(wr_data)));
endmodule

// File: rtl/wd_down_counter.sv
module wd_down_counter #(
  parameter int FIELD_W = 8,
  parameter int GRACE   = 1,
  localparam int CNT_W  = FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FIELD_W-1:0] load_field,
  input  logic               load_run,
  input  logic               tick_en,
  input  logic               in_grace,
  output logic               expire,
  output logic [CNT_W-1:0]   cnt_q
);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(1) << FIELD_W;
  localparam logic [CNT_W-1:0] GRACE_CNT = CNT_W'(GRACE);

  logic run_q;

  assign expire = run_q && tick_en && !load && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= (load_field == '0) ? FULL_CNT : {1'b0, load_field};
      run_q <= load_run;
    end else if (expire) begin
      if (!in_grace) begin
        cnt_q <= GRACE_CNT;
      end else begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end
    end else if (run_q && tick_en) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R5/R6: a stopped counter, or a cycle with no tick, holds the count
  assert_hold_without_tick_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && (!run_q || !tick_en)) |=> $stable(cnt_q));
  // R4: an empty count field becomes the full range
  assert_zero_field_full_R4: assert property (@(posedge clk) disable iff (rst)
    (load && load_field == '0) |=> (cnt_q == FULL_CNT));
endmodule

// File: rtl/wd_escalate.sv
module wd_escalate
  import keyed_watchdog_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic service,
  input  logic expire,
  output logic in_grace,
  output logic nmi_q,
  output logic reset_req_q
);
  stage_e stage_q;

  assign in_grace = (stage_q == STG_GRACE);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q     <= STG_ARMED;
      nmi_q       <= 1'b0;
      reset_req_q <= 1'b0;
    end else begin
      reset_req_q <= expire && in_grace;
      if (service) begin
        stage_q <= STG_ARMED;
        nmi_q   <= 1'b0;
      end else if (expire && !in_grace) begin
        stage_q <= STG_GRACE;
        nmi_q   <= 1'b1;
      end
    end
  end

  // R8: the reset request never lasts two cycles
  assert_reset_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    reset_req_q |=> !reset_req_q);
  // R9: service drops the interrupt
  assert_service_clears_nmi_R9: assert property (@(posedge clk) disable iff (rst)
    service |=> !nmi_q);
  // R7: the first expiry raises the interrupt
  assert_first_expiry_nmi_R7: assert property (@(posedge clk) disable iff (rst)
    (expire && !in_grace) |=> nmi_q);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int DATA_W  = 32,
  parameter int KEY_W   = 7,
  parameter int KEY_LSB = 9,
  parameter int CMD_BIT = 8,
  parameter int FIELD_W = 8,
  parameter int GRACE   = 1,
  localparam int CNT_W  = FIELD_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick_en,
  output logic              nmi,
  output logic              reset_req,
  output logic [DATA_W-1:0] ctrl_value,
  output logic [CNT_W-1:0]  count_value
);
  logic accept;
  logic expire;
  logic in_grace;

  wd_key_gate #(
    .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_LSB(KEY_LSB), .CMD_BIT(CMD_BIT)
  ) u_gate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .accept(accept), .ctrl_q(ctrl_value)
  );

  wd_down_counter #(
    .FIELD_W(FIELD_W), .GRACE(GRACE)
  ) u_cnt (
    .clk(clk), .rst(rst), .load(accept), .load_field(wr_data[FIELD_W-1:0]),
    .load_run(wr_data[CMD_BIT]), .tick_en(tick_en), .in_grace(in_grace),
    .expire(expire), .cnt_q(count_value)
  );

  wd_escalate u_esc (
    .clk(clk), .rst(rst), .service(accept), .expire(expire),
    .in_grace(in_grace), .nmi_q(nmi), .reset_req_q(reset_req)
  );

  // R10: a tick in the same cycle as an accepted write does not count
  assert_write_beats_tick_R10: assert property (@(posedge clk) disable iff (rst)
    (accept && tick_en) |=> (!nmi && !reset_req));
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  localparam int GRACE = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        tick_en = 1'b0;
  logic        nmi, reset_req;
  logic [31:0] ctrl_value;
  logic [8:0]  count_value;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // behavioural reference state
  int m_ctrl = 0, m_cnt = 0, m_run = 0, m_hit = 0, m_nmi = 0, m_rr = 0;

  always #5 clk = ~clk;

  keyed_watchdog #(.GRACE(GRACE)) i_keyed_watchdog (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .tick_en(tick_en),
    .nmi(nmi), .reset_req(reset_req), .ctrl_value(ctrl_value), .count_value(count_value)
  );

  function automatic logic [31:0] word(int key, int cmd, int cnt);
    return 32'((key & 127) << 9) | 32'((cmd & 1) << 8) | 32'(cnt & 255);
  endfunction

  task automatic compare(string req);
    vectors++;
    if (nmi !== m_nmi[0] || reset_req !== m_rr[0] ||
        ctrl_value !== 32'(m_ctrl) || count_value !== 9'(m_cnt)) begin
      errors++;
      $display("FAIL %s: got nmi=%0b rr=%0b ctrl=%h cnt=%0d, expected nmi=%0b rr=%0b ctrl=%h cnt=%0d",
               req, nmi, reset_req, ctrl_value, count_value, m_nmi, m_rr, m_ctrl, m_cnt);
    end
  endtask

  task automatic step(bit w, logic [31:0] d, bit t, string req);
    int okey, nkey;
    wr_en = w; wr_data = d; tick_en = t;
    @(posedge clk);
    okey = (m_ctrl >> 9) & 127;
    nkey = int'((d >> 9) & 32'd127);
    m_rr = 0;
    if (w && ((((m_ctrl >> 8) & 1) == 0) || nkey == ((~okey) & 127))) begin
      m_ctrl = int'(d);
      m_cnt  = ((d & 32'd255) == 0) ? 256 : int'(d & 32'd255);
      m_run  = int'((d >> 8) & 32'd1);
      m_hit  = 0;
      m_nmi  = 0;
    end else if (m_run != 0 && t) begin
      if (m_cnt > 1) m_cnt--;
      else if (m_hit == 0) begin m_hit = 1; m_nmi = 1; m_cnt = GRACE; end
      else begin m_rr = 1; m_run = 0; m_cnt = 0; end
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic ticks(int n, string req);
    for (int i = 0; i < n; i++) step(0, '0, 1, req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, got running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare("R1");
    // R6: idle ticks with nothing running
    ticks(3, "R6");
    // R2: first write after reset, any key
    step(1, word(7'h5a, 1, 3), 0, "R2");
    step(0, '0, 0, "R6");
    ticks(1, "R6");
    // R3: key equal to stored (not inverse) is rejected
    step(1, word(7'h5a, 1, 9), 0, "R3");
    step(1, word(7'h00, 0, 9), 1, "R3");
    // R4: inverse key accepted, count field 0 -> 256
    step(1, word(7'h25, 1, 0), 0, "R4");
    ticks(5, "R6");
    // R5: stop with command 0, ticks then ignored
    step(1, word(7'h5a, 0, 4), 0, "R5");
    ticks(4, "R5");
    // R2: stopped -> unkeyed write accepted
    step(1, word(7'h11, 1, 2), 0, "R2");
    // R7: expiry -> nmi with grace
    ticks(2, "R7");
    // R9: service clears nmi
    step(1, word(7'h6e, 1, 2), 0, "R9");
    ticks(2, "R7");
    // R8: grace expiry -> one-cycle reset request, then stopped
    ticks(1, "R8");
    step(0, '0, 0, "R8");
    ticks(3, "R8");
    // R10: write coincides with expiring tick
    step(1, word(7'h11, 1, 1), 1, "R10");
    step(1, word(7'h6e, 1, 1), 1, "R10");
    step(0, '0, 0, "R10");
    // R4: full 256 count to expiry
    step(1, word(7'h11, 1, 0), 0, "R4");
    ticks(256, "R7");
    ticks(1, "R8");
    // mixed pseudo-random traffic
    begin
      int seed_key = 3;
      step(1, word(seed_key, 1, 5), 0, "R3");
      for (int i = 0; i < 3000; i++) begin
        int r = int'($urandom_range(0, 99));
        int k = ((m_ctrl >> 9) & 127);
        if (r < 6)       step(1, word(~k, 1, int'($urandom_range(0, 12))), r[0], "R3");
        else if (r < 10) step(1, word(k ^ int'($urandom_range(1, 127)), 1, 3), r[0], "R3");
        else if (r < 11) step(1, word(~k, 0, 4), 0, "R5");
        else             step(0, '0, (r % 3) != 0, "R6");
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule